// File: doc/BRIEF.md
# Interrupt Pending Aggregator

This block gathers completion events from the device's internal engines and software-issued test bits into one 32-bit pending word. Each bit stays pending until software acknowledges it. Two hardware strobes feed fixed bits: the factorial engine lands in bit 0 and the DMA engine lands in bit 8. Software can also raise any pattern of bits through a set register and drop bits through a separate clear register. The pending word is read back through the same register port.

Each raise is announced in one of two ways, chosen by a mode input. In message mode the block issues a single-cycle request pulse. In level mode it holds an interrupt line high. The line falls only when an acknowledge leaves nothing pending while the block is in level mode. Switching to message mode never drops a line that is already high.

Top module: `intr_hub`

## Requirements
- R1: After reset the pending word is zero, `irq_level` is 0 and `msg_req` is 0.
- R2: `reg_rdata` shows the pending word when `reg_rd` is high and `reg_addr` is 0x24. In every other case it is zero. The value shown in a cycle is the word as updated at the preceding clock edge.
- R3: A write to offset 0x60 ORs `reg_wdata` into the pending word at the next edge. The write counts as a raise event even when the data is zero.
- R4: A write to offset 0x64 clears the pending bits that are 1 in `reg_wdata` at the next edge.
- R5: `hw_raise[0]` sets pending bit 0 and `hw_raise[1]` sets pending bit 8. Each strobe is a raise event.
- R6: When a hardware strobe and a clear write hit the same bit in the same cycle, the bit ends up set.
- R7: In level mode (`msg_mode`=0), a raise event that leaves the pending word non-zero drives `irq_level` to 1 at the next edge.
- R8: `irq_level` falls only at the edge after a clear write that leaves the pending word zero while `msg_mode`=0. A clear to zero in message mode leaves the line as it was.
- R9: In message mode, a raise event that leaves the pending word non-zero produces a one-cycle `msg_req` pulse at the next edge. `irq_level` is not changed.
- R10: Several raise events in the same cycle (hardware strobes plus a set write) produce exactly one pulse.
- R11: A set write of zero while nothing is pending produces neither a pulse nor a line change.
- R12: Writes to any other offset, including 0x24, leave the pending word and both outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read enable |
| reg_addr | input | ADDR_W (8) | Register byte offset |
| reg_wdata | input | 32 | Write data (mask) |
| reg_rdata | output | 32 | Read data |
| hw_raise | input | NUM_SRC (2) | Engine completion strobes |
| msg_mode | input | 1 | 1 selects message pulses, 0 selects the level line |
| irq_level | output | 1 | Level interrupt line |
| msg_req | output | 1 | Single-cycle message request |

## Verification
The bench builds the block with its default parameters: an 8-bit offset space and two hardware sources mapped to bits 0 and 8. That mapping lets one strobe and a software clear collide on the same bit. It also lets a set write and both strobes land in a single cycle. The bench changes the mode while the line is high, so it reaches the case where a clear to zero must leave the line untouched.

// File: rtl/intr_hub_pkg.sv
package intr_hub_pkg;
  localparam int unsigned PEND_W = 32;
  localparam int unsigned POS_W  = $clog2(PEND_W);

  localparam int unsigned OFS_PEND = 'h24;
  localparam int unsigned OFS_SET  = 'h60;
  localparam int unsigned OFS_CLR  = 'h64;

  typedef logic [PEND_W-1:0] pend_t;

  // Software set and clear first, then hardware bits on top so they win.
  function automatic pend_t merge_pending(pend_t cur, pend_t set_m,
                                          pend_t clr_m, pend_t hw_m);
    return ((cur | set_m) & ~clr_m) | hw_m;
  endfunction

  // A raise only announces itself when something remains pending.
  function automatic logic raise_lands(logic raise, pend_t nxt);
    return raise && (nxt != '0);
  endfunction
endpackage

// File: rtl/intr_hub_decode.sv
module intr_hub_decode
  import intr_hub_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  pend_t             reg_wdata,
  output logic              set_evt,
  output logic              clr_evt,
  output pend_t             set_mask,
  output pend_t             clr_mask
);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_CLR);

  always_comb begin
    set_evt  = reg_wr && (reg_addr == A_SET);
    clr_evt  = reg_wr && (reg_addr == A_CLR);
    set_mask = set_evt ? reg_wdata : '0;
    clr_mask = clr_evt ? reg_wdata : '0;
  end

  always_comb begin
    AST_ONE_WRITE_KIND: assert (!(set_evt && clr_evt)); // R12
  end
endmodule

// File: rtl/intr_hub_status.sv
module intr_hub_status
  import intr_hub_pkg::*;
#(
  parameter int unsigned NUM_SRC = 2,
  parameter logic [NUM_SRC*POS_W-1:0] SRC_POS = {5'd8, 5'd0}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] hw_raise,
  input  logic               set_evt,
  input  logic               clr_evt,
  input  pend_t              set_mask,
  input  pend_t              clr_mask,
  output pend_t              pending,
  output pend_t              pending_nxt,
  output logic               raise_evt
);
  pend_t hw_mask;
  pend_t src_bit [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_comb begin
      src_bit[g] = '0;
      src_bit[g][SRC_POS[g*POS_W +: POS_W]] = hw_raise[g];
    end
  end

  always_comb begin
    hw_mask = '0;
    for (int i = 0; i < NUM_SRC; i++) hw_mask = hw_mask | src_bit[i];
  end

  assign pending_nxt = merge_pending(pending, set_mask, clr_mask, hw_mask);
  assign raise_evt   = set_evt || (|hw_raise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= '0;
    else        pending <= pending_nxt;
  end

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> ((pending & $past(set_mask)) == $past(set_mask))); // R3
  AST_CLEAR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> ((pending & $past(clr_mask & ~hw_mask)) == '0)); // R4
  AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_raise) |=> ((pending & $past(hw_mask)) == $past(hw_mask))); // R6
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_evt && !clr_evt && !(|hw_raise)) |=> $stable(pending)); // R12
endmodule

// File: rtl/intr_hub_signal.sv
module intr_hub_signal
  import intr_hub_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  raise_evt,
  input  logic  clr_evt,
  input  logic  msg_mode,
  input  pend_t pending,
  input  pend_t pending_nxt,
  output logic  irq_level,
  output logic  msg_req
);
  logic lands, drop_ok;

  assign lands   = raise_lands(raise_evt, pending_nxt);
  assign drop_ok = clr_evt && (pending_nxt == '0) && !msg_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_level <= 1'b0;
      msg_req   <= 1'b0;
    end else begin
      msg_req <= lands && msg_mode;
      if (lands && !msg_mode) irq_level <= 1'b1;
      else if (drop_ok)       irq_level <= 1'b0;
    end
  end

  AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req |-> (pending != '0)); // R9
  AST_PULSE_IN_MSG_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req |-> $past(msg_mode)); // R9
  AST_LINE_RISE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_level) |-> !$past(msg_mode)); // R7
  AST_LINE_FALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_level) |-> ((pending == '0) && !$past(msg_mode))); // R8
endmodule

// File: rtl/intr_hub.sv
module intr_hub
  import intr_hub_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NUM_SRC = 2,
  parameter logic [NUM_SRC*POS_W-1:0] SRC_POS = {5'd8, 5'd0}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_SRC-1:0] hw_raise,
  input  logic               msg_mode,
  output logic               irq_level,
  output logic               msg_req
);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);

  logic  set_evt, clr_evt, raise_evt;
  pend_t set_mask, clr_mask, pending, pending_nxt;

  intr_hub_decode #(.ADDR_W(ADDR_W)) u_decode (
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .set_evt  (set_evt),
    .clr_evt  (clr_evt),
    .set_mask (set_mask),
    .clr_mask (clr_mask)
  );

  intr_hub_status #(.NUM_SRC(NUM_SRC), .SRC_POS(SRC_POS)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_raise   (hw_raise),
    .set_evt    (set_evt),
    .clr_evt    (clr_evt),
    .set_mask   (set_mask),
    .clr_mask   (clr_mask),
    .pending    (pending),
    .pending_nxt(pending_nxt),
    .raise_evt  (raise_evt)
  );

  intr_hub_signal u_signal (
    .clk        (clk),
    .rst_n      (rst_n),
    .raise_evt  (raise_evt),
    .clr_evt    (clr_evt),
    .msg_mode   (msg_mode),
    .pending    (pending),
    .pending_nxt(pending_nxt),
    .irq_level  (irq_level),
    .msg_req    (msg_req)
  );

  assign reg_rdata = (reg_rd && (reg_addr == A_PEND)) ? pending : '0;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!msg_req && !irq_level)); // R1
endmodule

// File: tb/test_intr_hub.sv
`timescale 1ns/1ps
module test_intr_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, msg_mode = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  hw_raise = '0;
  logic        irq_level, msg_req;

  always #5 clk = ~clk;

  intr_hub i_intr_hub (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hw_raise(hw_raise), .msg_mode(msg_mode),
    .irq_level(irq_level), .msg_req(msg_req)
  );

  typedef struct {
    logic [31:0] rdata;
    logic        lvl;
    logic        msg;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0, errors = 0;
  bit          done = 1'b0;
  logic [31:0] m_pend = '0;
  logic        m_lvl = 1'b0;

  // Bench-side model, written bit by bit from the requirements.
  task automatic step(input logic wr, input logic rd, input logic [7:0] addr,
                      input logic [31:0] data, input logic [1:0] hw,
                      input logic mode, input string tag);
    logic [31:0] np;
    logic raise, landed;
    exp_t e;
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = addr; reg_wdata = data;
    hw_raise = hw; msg_mode = mode;
    np = m_pend;
    for (int b = 0; b < 32; b++) begin
      if (wr && addr == 8'h60 && data[b]) np[b] = 1'b1;
      if (wr && addr == 8'h64 && data[b]) np[b] = 1'b0;
    end
    if (hw[0]) np[0] = 1'b1;
    if (hw[1]) np[8] = 1'b1;
    raise  = (wr && addr == 8'h60) || hw != 2'b00;
    landed = raise && (np != 32'h0);
    if (landed && !mode) m_lvl = 1'b1;
    else if (wr && addr == 8'h64 && np == 32'h0 && !mode) m_lvl = 1'b0;
    m_pend  = np;
    e.rdata = (rd && addr == 8'h24) ? np : 32'h0;
    e.lvl   = m_lvl;
    e.msg   = landed && mode;
    e.tag   = tag;
    sb.push_back(e);
  endtask

  task automatic peek(input logic mode, input string tag);
    step(1'b0, 1'b1, 8'h24, 32'h0, 2'b00, mode, tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (reg_rdata !== e.rdata || irq_level !== e.lvl || msg_req !== e.msg) begin
          errors++;
          $display("FAIL %s: rdata=%h lvl=%b msg=%b expected rdata=%h lvl=%b msg=%b",
                   e.tag, reg_rdata, irq_level, msg_req, e.rdata, e.lvl, e.msg);
        end
      end
    end
  end

  initial begin : watchdog
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    peek(1'b0, "R1 reset state");
    step(1'b1, 1'b0, 8'h60, 32'h0, 2'b00, 1'b0, "R11 zero set with nothing pending");
    peek(1'b0, "R11 pending still empty");
    step(1'b1, 1'b0, 8'h60, 32'h0000_0010, 2'b00, 1'b0, "R7 set raises line");
    peek(1'b0, "R3 set bit visible");
    step(1'b0, 1'b1, 8'h20, 32'h0, 2'b00, 1'b0, "R2 other offset reads zero");
    step(1'b1, 1'b0, 8'h24, 32'hFFFF_FFFF, 2'b00, 1'b0, "R12 write to status offset");
    step(1'b1, 1'b0, 8'h04, 32'hFFFF_FFFF, 2'b00, 1'b0, "R12 write to unused offset");
    peek(1'b0, "R12 pending unchanged");
    step(1'b0, 1'b1, 8'h24, 32'h0, 2'b01, 1'b0, "R5 factorial strobe bit 0");
    step(1'b0, 1'b1, 8'h24, 32'h0, 2'b10, 1'b0, "R5 dma strobe bit 8");
    step(1'b1, 1'b0, 8'h64, 32'h0000_0010, 2'b00, 1'b0, "R4 partial clear keeps line");
    peek(1'b0, "R4 cleared bit gone");
    step(1'b1, 1'b0, 8'h64, 32'h0000_0101, 2'b01, 1'b0, "R6 strobe beats clear");
    peek(1'b0, "R6 bit 0 survives");
    step(1'b1, 1'b0, 8'h64, 32'h0000_0001, 2'b00, 1'b0, "R8 clear to zero drops line");
    peek(1'b0, "R8 pending empty");
    step(1'b1, 1'b0, 8'h60, 32'h0000_0004, 2'b00, 1'b1, "R9 message pulse");
    peek(1'b1, "R9 pulse lasts one cycle");
    step(1'b1, 1'b0, 8'h60, 32'h0, 2'b00, 1'b1, "R3 zero set with pending pulses");
    step(1'b1, 1'b0, 8'h60, 32'h8000_0000, 2'b11, 1'b1, "R10 three raises one pulse");
    peek(1'b1, "R10 no second pulse");
    step(1'b1, 1'b0, 8'h64, 32'hFFFF_FFFF, 2'b00, 1'b1, "R8 message mode clear");
    step(1'b1, 1'b0, 8'h60, 32'h0000_0040, 2'b00, 1'b0, "R7 line up in level mode");
    step(1'b1, 1'b0, 8'h64, 32'hFFFF_FFFF, 2'b00, 1'b1, "R8 clear in message mode keeps line");
    step(1'b1, 1'b0, 8'h60, 32'h0000_0002, 2'b00, 1'b1, "R9 pulse while line high");
    step(1'b1, 1'b0, 8'h64, 32'h0000_0002, 2'b00, 1'b0, "R8 level mode clear drops line");
    peek(1'b0, "R2 final pending read");
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0; hw_raise = '0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule